// File: doc/BRIEF.md
# Bridge Address Window Decoder

The decoder sits between the two buses of a transparent bridge and classifies every address phase. It takes the address, whether the command is memory or I/O, whether it is a read or a write, and which side started it. It then decides whether the bridge should claim the cycle and carry it across. For downstream memory reads, it also decides whether the bridge may read ahead of the initiator.

Three address windows are programmed through base and limit fields: a memory window whose reads must not be prefetched, a memory window whose reads may be prefetched, and an I/O window. A cycle from the near side is claimed when it falls inside a window. A cycle from the far side is claimed when it falls outside all of them. A legacy video enable always routes the display frame buffer and the display register ports downstream. A palette-snoop enable routes only palette writes downstream. The decision is registered and appears one clock after the address strobe.

Top module: `bridge_window_decoder`

## Requirements
- R1: After reset, `dec_valid`, `claim`, `dir_down` and `pf_ok` are 0. `dec_valid` is 1 in the cycle after each cycle with `addr_valid` high and 0 otherwise. The other three outputs change only in the cycle after a strobe.
- R2: Each memory window compares address bits [31:20] with its 12-bit base and limit fields, inclusively. A window therefore covers every byte from base×1 MB up to limit×1 MB + FFFFFh.
- R3: A cycle from the near side (`from_far`=0) is claimed with `dir_down`=1 in two cases: a memory cycle inside either memory window, or an I/O cycle inside the I/O window.
- R4: A cycle from the far side (`from_far`=1) is claimed, with `dir_down`=0, only when its address falls outside every window of its class and outside the video ranges enabled for that class.
- R5: A window whose limit field is less than its base field matches nothing. For the I/O window this means no near-side I/O is forwarded by the window, and every far-side I/O outside the enabled video ports is claimed.
- R6: `pf_ok`=1 only for a near-side memory read that lies inside the prefetchable window, outside the non-prefetchable window and outside the enabled frame buffer. Writes, I/O cycles and far-side cycles give `pf_ok`=0.
- R7: With `vga_en`=1, two kinds of cycle are always claimed from the near side and never from the far side: memory at 000A0000h–000BFFFFh, and I/O at 03B0h–03BBh or 03C0h–03DFh (address bits [31:16] zero). This holds whatever the windows say.
- R8: With `vga_snoop`=1, a near-side I/O write to 03C6h, 03C8h or 03C9h is claimed. A palette read is not claimed by this rule. Far-side cycles are not affected by this rule.
- R9: The I/O window compares address bits [15:12] with its 4-bit base and limit fields, inclusively. It matches only when bits [31:16] are zero.
- R10: `dir_down` and `pf_ok` are 0 whenever `claim` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Address strobe, one cycle per address phase |
| addr | input | 32 | Address of the phase |
| is_io | input | 1 | 1 = I/O command, 0 = memory command |
| is_write | input | 1 | 1 = write, 0 = read |
| from_far | input | 1 | 1 = cycle started on the far side |
| np_base | input | 12 | Non-prefetchable window base, address bits [31:20] |
| np_limit | input | 12 | Non-prefetchable window limit, address bits [31:20] |
| pf_base | input | 12 | Prefetchable window base, address bits [31:20] |
| pf_limit | input | 12 | Prefetchable window limit, address bits [31:20] |
| io_base | input | 4 | I/O window base, address bits [15:12] |
| io_limit | input | 4 | I/O window limit, address bits [15:12] |
| vga_en | input | 1 | Route the video frame buffer and register ports downstream |
| vga_snoop | input | 1 | Route palette writes downstream |
| dec_valid | output | 1 | Decode result present |
| claim | output | 1 | Bridge claims the cycle |
| dir_down | output | 1 | Claimed cycle goes from the near side to the far side |
| pf_ok | output | 1 | Claimed read may be prefetched |

## Verification
On every cycle, the assertions check the strobe-to-valid timing and the hold of results between strobes. They also check that direction and prefetch never appear without a claim, that writes, I/O and far-side cycles never allow prefetch, and that a disabled I/O window with no video enables claims no near-side I/O. The assertions also check that the frame buffer is always claimed from the near side under the video enable. Only the bench scenarios can show the actual window arithmetic. That covers the inclusive 1 MB and 4 KB edges, the split between the prefetchable and non-prefetchable windows when they overlap, the inverse claim for far-side traffic, and the exact palette ports. The bench checks these against an independent model under random configurations.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam logic [31:0] FB_LO     = 32'h000A_0000;
  localparam logic [31:0] FB_HI     = 32'h000B_FFFF;
  localparam logic [15:0] MONO_LO   = 16'h03B0;
  localparam logic [15:0] MONO_HI   = 16'h03BB;
  localparam logic [15:0] COLOR_LO  = 16'h03C0;
  localparam logic [15:0] COLOR_HI  = 16'h03DF;
  localparam logic [15:0] PAL_MASK  = 16'h03C6;
  localparam logic [15:0] PAL_WADDR = 16'h03C8;
  localparam logic [15:0] PAL_DATA  = 16'h03C9;

  typedef struct packed {
    logic claim;
    logic down;
    logic pf;
  } bwd_result_t;
endpackage

// File: rtl/bwd_window.sv
module bwd_window #(
  parameter int AW = 32,
  parameter int FW = 12
) (
  input  logic [AW-1:0] addr_i,
  input  logic [FW-1:0] base_i,
  input  logic [FW-1:0] limit_i,
  output logic          hit_o
);
  localparam int LOW = AW - FW;

  logic [FW-1:0] field;
  logic          off;

  always_comb begin
    field = addr_i[AW-1:LOW];
    off   = (limit_i < base_i);
    hit_o = !off && (field >= base_i) && (field <= limit_i);
  end
endmodule

// File: rtl/bwd_vga.sv
module bwd_vga
  import bwd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              fb_o,
  output logic              port_o,
  output logic              pal_o
);
  logic [15:0] lo;
  logic        hi_zero;

  always_comb begin
    lo      = addr_i[15:0];
    hi_zero = (addr_i[ADDR_W-1:16] == '0);
    fb_o    = (addr_i >= ADDR_W'(FB_LO)) && (addr_i <= ADDR_W'(FB_HI));
    port_o  = hi_zero && (((lo >= MONO_LO) && (lo <= MONO_HI)) ||
                          ((lo >= COLOR_LO) && (lo <= COLOR_HI)));
    pal_o   = hi_zero && ((lo == PAL_MASK) || (lo == PAL_WADDR) || (lo == PAL_DATA));
  end
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MEM_GRAN   = 20,
  parameter int IO_SPACE_W = 16,
  parameter int IO_GRAN    = 12,
  localparam int MEM_FW    = ADDR_W - MEM_GRAN,
  localparam int IO_FW     = IO_SPACE_W - IO_GRAN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_io,
  input  logic              is_write,
  input  logic              from_far,
  input  logic [MEM_FW-1:0] np_base,
  input  logic [MEM_FW-1:0] np_limit,
  input  logic [MEM_FW-1:0] pf_base,
  input  logic [MEM_FW-1:0] pf_limit,
  input  logic [IO_FW-1:0]  io_base,
  input  logic [IO_FW-1:0]  io_limit,
  input  logic              vga_en,
  input  logic              vga_snoop,
  output logic              dec_valid,
  output logic              claim,
  output logic              dir_down,
  output logic              pf_ok
);
  localparam int NWIN = 2;

  logic [NWIN-1:0][MEM_FW-1:0] win_base, win_limit;
  logic [NWIN-1:0]             win_hit;
  logic                        io_win_hit, io_hit, io_hi_zero;
  logic                        fb_hit, port_hit, pal_hit;
  logic                        mem_in, io_down, io_excl;
  bwd_result_t                 res_d, res_q;
  logic                        valid_q;

  assign win_base  = {pf_base, np_base};
  assign win_limit = {pf_limit, np_limit};

  for (genvar g = 0; g < NWIN; g++) begin : g_memwin
    bwd_window #(.AW(ADDR_W), .FW(MEM_FW)) u_win (
      .addr_i (addr),
      .base_i (win_base[g]),
      .limit_i(win_limit[g]),
      .hit_o  (win_hit[g])
    );
  end

  bwd_window #(.AW(IO_SPACE_W), .FW(IO_FW)) u_iowin (
    .addr_i (addr[IO_SPACE_W-1:0]),
    .base_i (io_base),
    .limit_i(io_limit),
    .hit_o  (io_win_hit)
  );

  bwd_vga #(.ADDR_W(ADDR_W)) u_vga (
    .addr_i(addr),
    .fb_o  (fb_hit),
    .port_o(port_hit),
    .pal_o (pal_hit)
  );

  // next-state decode
  always_comb begin
    io_hi_zero = (addr[ADDR_W-1:IO_SPACE_W] == '0);
    io_hit     = io_win_hit && io_hi_zero;
    mem_in     = win_hit[0] || win_hit[1] || (vga_en && fb_hit);
    io_excl    = io_hit || (vga_en && port_hit);
    io_down    = io_excl || (vga_snoop && is_write && pal_hit);
    if (!from_far) res_d.claim = is_io ? io_down : mem_in;
    else           res_d.claim = is_io ? !io_excl : !mem_in;
    res_d.down = !from_far && res_d.claim;
    res_d.pf   = !from_far && !is_io && !is_write && win_hit[1] &&
                 !win_hit[0] && !(vga_en && fb_hit);
  end

  // register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= addr_valid;
      if (addr_valid) res_q <= res_d;
    end
  end

  assign dec_valid = valid_q;
  assign claim     = res_q.claim;
  assign dir_down  = res_q.down;
  assign pf_ok     = res_q.pf;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> dec_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> !dec_valid);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> ($stable(claim) && $stable(dir_down) && $stable(pf_ok)));
  assert_pf_needs_claim_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pf_ok |-> (claim && dir_down));
  assert_dir_needs_claim_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dir_down |-> claim);
  assert_pf_reads_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && (is_write || is_io || from_far)) |=> !pf_ok);
  assert_io_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && is_io && !from_far && (io_limit < io_base) && !vga_en && !vga_snoop)
    |=> !claim);
  assert_vga_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && vga_en && !is_io && !from_far && fb_hit) |=> (claim && dir_down));
endmodule

// File: tb/bridge_window_decoder_bench.sv
module bridge_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_valid, is_io, is_write, from_far, vga_en, vga_snoop;
  logic [31:0] addr;
  logic [11:0] np_base, np_limit, pf_base, pf_limit;
  logic [3:0]  io_base, io_limit;
  logic        dec_valid, claim, dir_down, pf_ok;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  bridge_window_decoder u_bridge_window_decoder (
    .clk, .rst_n, .addr_valid, .addr, .is_io, .is_write, .from_far,
    .np_base, .np_limit, .pf_base, .pf_limit, .io_base, .io_limit,
    .vga_en, .vga_snoop, .dec_valid, .claim, .dir_down, .pf_ok
  );

  function automatic bit inwin12(logic [11:0] f, logic [11:0] b, logic [11:0] l);
    return (l >= b) && (f >= b) && (f <= l);
  endfunction

  // expected {claim, dir_down, pf_ok} from the requirements
  function automatic logic [2:0] model();
    bit np, pf, io, fb, port, pal, hz, c, p;
    np   = inwin12(addr[31:20], np_base, np_limit);
    pf   = inwin12(addr[31:20], pf_base, pf_limit);
    hz   = (addr[31:16] == 16'h0);
    io   = hz && inwin12({8'h0, addr[15:12]}, {8'h0, io_base}, {8'h0, io_limit});
    fb   = vga_en && (addr >= 32'hA0000) && (addr <= 32'hBFFFF);
    port = vga_en && hz && ((addr[15:0] >= 16'h3B0 && addr[15:0] <= 16'h3BB) ||
                            (addr[15:0] >= 16'h3C0 && addr[15:0] <= 16'h3DF));
    pal  = hz && (addr[15:0] == 16'h3C6 || addr[15:0] == 16'h3C8 || addr[15:0] == 16'h3C9);
    if (!from_far) c = is_io ? (io || port || (vga_snoop && is_write && pal)) : (np || pf || fb);
    else           c = is_io ? !(io || port) : !(np || pf || fb);
    p = !from_far && !is_io && !is_write && pf && !np && !fb;
    return {c, c && !from_far, p};
  endfunction

  task automatic check(string tag, logic [2:0] exp);
    checks++;
    if (!dec_valid || {claim, dir_down, pf_ok} !== exp) begin
      errors++;
      $display("FAIL %s: actual valid=%b {claim,dir,pf}=%b expected valid=1 %b",
               tag, dec_valid, {claim, dir_down, pf_ok}, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at next negedge
  task automatic apply(string tag, logic [31:0] a, bit io, bit wr, bit far);
    logic [2:0] exp;
    addr = a; is_io = io; is_write = wr; from_far = far; addr_valid = 1'b1;
    exp = model();
    @(negedge clk);
    addr_valid = 1'b0;
    check(tag, exp);
  endtask

  task automatic setcfg(logic [11:0] nb, logic [11:0] nl, logic [11:0] pb,
                        logic [11:0] pl, logic [3:0] ib, logic [3:0] il, bit ve, bit vs);
    np_base = nb; np_limit = nl; pf_base = pb; pf_limit = pl;
    io_base = ib; io_limit = il; vga_en = ve; vga_snoop = vs;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; addr_valid = 1'b0; addr = '0; is_io = 0; is_write = 0; from_far = 0;
    setcfg(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    checks++;
    if ({dec_valid, claim, dir_down, pf_ok} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset: actual %b expected 0000", {dec_valid, claim, dir_down, pf_ok});
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 inclusive 1 MB edges, R3 downstream claim
    setcfg(12'h001, 12'h001, 12'h004, 12'h007, 4'h1, 4'h2, 0, 0);
    apply("R2 top byte of window", 32'h001F_FFFF, 0, 0, 0);
    apply("R2 first byte past limit", 32'h0020_0000, 0, 0, 0);
    apply("R3 np window write down", 32'h0010_0000, 0, 1, 0);
    // R6 prefetch
    apply("R6 pf read down", 32'h0050_0010, 0, 0, 0);
    apply("R6 pf write down", 32'h0050_0010, 0, 1, 0);
    apply("R4 pf read from far inside", 32'h0050_0010, 0, 0, 1);
    apply("R4 memory from far outside", 32'h0900_0000, 0, 0, 1);
    setcfg(12'h004, 12'h005, 12'h004, 12'h007, 4'h1, 4'h2, 0, 0);
    apply("R6 overlap np wins", 32'h0040_0000, 0, 0, 0);
    // R9 I/O window
    apply("R9 io top of window", 32'h0000_2FFF, 1, 0, 0);
    apply("R9 io past window", 32'h0000_3000, 1, 0, 0);
    apply("R9 io high bits set", 32'h0001_1000, 1, 0, 0);
    // R5 disabled I/O window
    setcfg(12'h001, 12'h000, 12'h004, 12'h007, 4'h5, 4'h2, 0, 0);
    apply("R5 io disabled down", 32'h0000_3000, 1, 1, 0);
    apply("R5 io disabled far", 32'h0000_3000, 1, 1, 1);
    apply("R5 mem disabled window down", 32'h0010_0000, 0, 0, 0);
    // R7 video ranges
    setcfg(0, 0, 12'h000, 12'h000, 4'h5, 4'h2, 1, 0);
    apply("R7 fb read down no pf", 32'h000A_0000, 0, 0, 0);
    apply("R7 fb far side", 32'h000B_FFFF, 0, 0, 1);
    apply("R7 port 3DF down", 32'h0000_03DF, 1, 0, 0);
    apply("R7 port 3BC not video", 32'h0000_03BC, 1, 0, 0);
    // R8 snoop
    setcfg(12'h001, 12'h000, 12'h001, 12'h000, 4'h5, 4'h2, 0, 1);
    apply("R8 palette write", 32'h0000_03C8, 1, 1, 0);
    apply("R8 palette read", 32'h0000_03C9, 1, 0, 0);
    apply("R8 non palette write", 32'h0000_03C7, 1, 1, 0);
    apply("R8 far palette write", 32'h0000_03C6, 1, 1, 1);

    // R1 hold without strobe
    apply("R1 strobe before hold", 32'h0000_03C8, 1, 1, 0);
    held = {claim, dir_down, pf_ok};
    addr = 32'h0000_03C7; is_write = 0;
    @(negedge clk);
    checks++;
    if (dec_valid !== 1'b0 || {claim, dir_down, pf_ok} !== held) begin
      errors++;
      $display("FAIL R1 hold: actual valid=%b %b expected valid=0 %b",
               dec_valid, {claim, dir_down, pf_ok}, held);
    end

    // constrained random, R2 to R10
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      if (i % 20 == 0)
        setcfg(12'($urandom % 16), 12'($urandom % 16), 12'($urandom % 16), 12'($urandom % 16),
               4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
      case ($urandom % 5)
        0: a = $urandom;
        1: a = {8'h0, 4'($urandom), 20'($urandom)};
        2: a = 32'h9FFF0 + ($urandom % 32'h20020);
        3: a = {16'h0, 16'($urandom)};
        default: a = 32'h3A0 + ($urandom % 32'h50);
      endcase
      apply("R10 random", a, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule